// File: doc/BRIEF.md
# Sector Transfer Sequencer

This block paces one channel of a disk-style controller through programmed-I/O sector reads and writes. A register front end hands it a command byte together with the sector-count, starting block, interrupt-mask and ready-delay values. The sequencer then moves the host through an on-chip sector buffer one sector at a time. Between sectors it holds a busy phase of programmable length. It exchanges whole sectors with a backing media port, one byte per acknowledged beat, and it reports progress through a status byte and a one-cycle interrupt event.

A read begins by fetching one sector from the media before the host may read anything. After that, each sector the host drains triggers a fetch of the next one. A write lets the host fill the buffer first, and each full sector is pushed to the media before the remaining count drops. A sector-count value of zero requests 256 sectors. Accesses that break the protocol are ignored and leave a sticky error flag set.

Top module: `sector_seq`

## Requirements
- R1: After reset the status byte is 0x40, no media request is raised, the error flag is low and no interrupt event is present.
- R2: In the idle state, command 0x20 or 0x21 starts a read and command 0x30 or 0x31 starts a write. Any other command code leaves the block idle with no media request and no error.
- R3: The number of sectors moved equals `sect_count`, and a value of 0 moves 256 sectors.
- R4: The status byte is 0x08 while the host may fill or drain the buffer, 0x80 while a media transfer or busy phase runs, and 0x40 when idle.
- R5: A read first fetches the sector at byte address `start_lba * SECT_BYTES` from the media, then passes through a busy phase before the status first shows 0x08.
- R6: Every media transfer of a command targets a byte address one sector size above the previous one, starting at `start_lba * SECT_BYTES`, and `med_addr` holds steady while a request is up.
- R7: On a write, the bytes the host wrote for a sector are delivered to the media in order, with `med_we` high and byte index `med_idx` counting 0 upward, before the busy phase begins.
- R8: A busy phase lasts `ready_delay + 1` cycles, so a delay of zero ends it on the next clock.
- R9: Each busy phase ends with a one-cycle `irq_set` pulse, raised in the same cycle the status leaves 0x80, unless `irq_mask` was high.
- R10: A command while not idle, a host write outside the fill phase, or a host read outside the drain phase sets `proto_err`. The access has no other effect, and the flag stays set until reset.
- R11: During a read, `host_rdata` shows the buffer bytes in media order, and each `host_rd` advances to the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| sect_count | input | 8 | Sector count, 0 means 256 |
| start_lba | input | LBA_W | First block number |
| irq_mask | input | 1 | Suppresses interrupt events (control bit 1) |
| ready_delay | input | DELAY_W | Extra busy cycles after each sector |
| host_wr | input | 1 | Host writes one byte to the buffer |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host consumes one byte from the buffer |
| host_rdata | output | 8 | Current buffer byte for the host |
| status | output | 8 | Status byte |
| irq_set | output | 1 | One-cycle interrupt request event |
| proto_err | output | 1 | Sticky protocol error flag |
| med_req | output | 1 | Media transfer in progress |
| med_we | output | 1 | 1 = push to media, 0 = fetch from media |
| med_addr | output | LBA_W+log2(SECT_BYTES) | Byte address of the sector being moved |
| med_idx | output | log2(SECT_BYTES) | Byte index inside the sector |
| med_wdata | output | 8 | Byte delivered to the media |
| med_ack | input | 1 | Media accepts or supplies the current byte |
| med_rdata | input | 8 | Byte supplied by the media |

## Verification
Status, `host_rdata` and `proto_err` are due one clock after the stimulus edge. The bench drives each input on a falling edge and reads these outputs on the next falling edge. The busy phase is measured from the falling edge after the last host byte, and the status must read 0x80 for exactly `ready_delay + 1` falling edges. The `irq_set` pulse must appear on the first falling edge where the status is 0x40 or 0x08. Media bytes are checked on the falling edge where the bench raises `med_ack`, since the design consumes them at the rising edge that follows.

// File: rtl/sector_seq.sv
module sector_seq #(
  parameter int SECT_BYTES = 512,
  parameter int LBA_W      = 28,
  parameter int DELAY_W    = 16,
  localparam int PTR_W     = $clog2(SECT_BYTES),
  localparam int MADDR_W   = LBA_W + PTR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_code,
  input  logic [7:0]         sect_count,
  input  logic [LBA_W-1:0]   start_lba,
  input  logic               irq_mask,
  input  logic [DELAY_W-1:0] ready_delay,
  input  logic               host_wr,
  input  logic [7:0]         host_wdata,
  input  logic               host_rd,
  output logic [7:0]         host_rdata,
  output logic [7:0]         status,
  output logic               irq_set,
  output logic               proto_err,
  output logic               med_req,
  output logic               med_we,
  output logic [MADDR_W-1:0] med_addr,
  output logic [PTR_W-1:0]   med_idx,
  output logic [7:0]         med_wdata,
  input  logic               med_ack,
  input  logic [7:0]         med_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_DRAIN, S_FETCH, S_PUSH, S_BUSYL, S_BUSYD} st_t;

  st_t                state;
  logic [PTR_W-1:0]   ptr;
  logic [8:0]         rem;
  logic [MADDR_W-1:0] addr;
  logic [DELAY_W-1:0] dcnt;
  logic [7:0]         mem [SECT_BYTES];

  wire last      = (ptr == PTR_W'(SECT_BYTES - 1));
  wire host_take = host_wr && (state == S_LOAD);
  wire host_give = host_rd && (state == S_DRAIN);
  wire is_rd_cmd = (cmd_code == 8'h20) || (cmd_code == 8'h21);
  wire is_wr_cmd = (cmd_code == 8'h30) || (cmd_code == 8'h31);
  wire bad_acc   = (host_wr && state != S_LOAD) || (host_rd && state != S_DRAIN) ||
                   (cmd_valid && state != S_IDLE);
  wire [8:0] cnt_init = (sect_count == 8'd0) ? 9'd256 : {1'b0, sect_count};

  assign med_req    = (state == S_FETCH) || (state == S_PUSH);
  assign med_we     = (state == S_PUSH);
  assign med_addr   = addr;
  assign med_idx    = ptr;
  assign med_wdata  = mem[ptr];
  assign host_rdata = mem[ptr];

  always_comb begin
    case (state)
      S_IDLE:          status = 8'h40;
      S_LOAD, S_DRAIN: status = 8'h08;
      default:         status = 8'h80;
    endcase
  end

  always_ff @(posedge clk) begin
    if (host_take)
      mem[ptr] <= host_wdata;
    else if (state == S_FETCH && med_ack)
      mem[ptr] <= med_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr       <= '0;
      rem       <= '0;
      addr      <= '0;
      dcnt      <= '0;
      irq_set   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      irq_set <= 1'b0;
      if (bad_acc) proto_err <= 1'b1;
      case (state)
        S_IDLE: if (cmd_valid && (is_rd_cmd || is_wr_cmd)) begin
          state <= is_rd_cmd ? S_FETCH : S_LOAD;
          rem   <= cnt_init;
          addr  <= {start_lba, PTR_W'(0)};
          ptr   <= '0;
        end
        S_LOAD: if (host_take) begin
          ptr <= ptr + PTR_W'(1);
          if (last) state <= S_PUSH;
        end
        S_PUSH: if (med_ack) begin
          ptr <= ptr + PTR_W'(1);
          if (last) begin
            rem   <= rem - 9'd1;
            addr  <= addr + MADDR_W'(SECT_BYTES);
            dcnt  <= ready_delay;
            state <= S_BUSYL;
          end
        end
        S_FETCH: if (med_ack) begin
          ptr <= ptr + PTR_W'(1);
          if (last) begin
            dcnt  <= ready_delay;
            state <= S_BUSYD;
          end
        end
        S_DRAIN: if (host_give) begin
          ptr <= ptr + PTR_W'(1);
          if (last) begin
            rem   <= rem - 9'd1;
            addr  <= addr + MADDR_W'(SECT_BYTES);
            dcnt  <= ready_delay;
            state <= (rem != 9'd1) ? S_FETCH : S_BUSYD;
          end
        end
        S_BUSYL, S_BUSYD: begin
          if (dcnt == '0) begin
            irq_set <= !irq_mask;
            if (rem == 9'd0) state <= S_IDLE;
            else             state <= (state == S_BUSYL) ? S_LOAD : S_DRAIN;
          end else begin
            dcnt <= dcnt - DELAY_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IRQ_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> $past(state == S_BUSYL || state == S_BUSYD)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> !$past(irq_mask)); // R9
  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && state != S_IDLE) |=> proto_err); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R10
  AST_MED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (med_req && $past(med_req)) |-> $stable(med_addr)); // R6
  AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD || state == S_DRAIN) |-> rem != 9'd0); // R3

endmodule

// File: tb/tb_sector_seq.sv
module tb_sector_seq;
  localparam int SB = 4;

  typedef struct packed {
    logic        wr;
    logic [7:0]  cmd;
    logic [7:0]  cnt;
    logic [27:0] lba;
    logic [15:0] dly;
    logic        mask;
    logic [8:0]  nsec;
    logic [8:0]  nirq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 8'h20, 8'd3, 28'h10,   16'd2, 1'b0, 9'd3, 9'd4},
    '{1'b0, 8'h21, 8'd1, 28'h123,  16'd0, 1'b0, 9'd1, 9'd2},
    '{1'b1, 8'h30, 8'd2, 28'h40,   16'd1, 1'b0, 9'd2, 9'd2},
    '{1'b1, 8'h31, 8'd1, 28'h7,    16'd5, 1'b1, 9'd1, 9'd0},
    '{1'b0, 8'h20, 8'd2, 28'h55,   16'd3, 1'b1, 9'd2, 9'd0},
    '{1'b1, 8'h30, 8'd4, 28'h3000, 16'd0, 1'b0, 9'd4, 9'd4}
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0; logic [7:0] cmd_code = 0, sect_count = 0;
  logic [27:0] start_lba = 0; logic irq_mask = 0; logic [15:0] ready_delay = 0;
  logic host_wr = 0, host_rd = 0; logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata, status;
  logic irq_set, proto_err, med_req, med_we;
  logic [29:0] med_addr; logic [1:0] med_idx; logic [7:0] med_wdata;
  logic med_ack = 0; logic [7:0] med_rdata = 0;

  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  logic ack_alt = 0, tog = 0, a_next;
  longint exp_raddr = 0, exp_waddr = 0;

  always #2 clk = ~clk;

  sector_seq #(.SECT_BYTES(SB)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sect_count(sect_count), .start_lba(start_lba), .irq_mask(irq_mask),
    .ready_delay(ready_delay), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .status(status),
    .irq_set(irq_set), .proto_err(proto_err), .med_req(med_req), .med_we(med_we),
    .med_addr(med_addr), .med_idx(med_idx), .med_wdata(med_wdata),
    .med_ack(med_ack), .med_rdata(med_rdata));

  function automatic logic [7:0] rpat(longint s, int i);
    return 8'(s * 5 + i * 17 + 1);
  endfunction
  function automatic logic [7:0] wpat(longint s, int i);
    return 8'((s * 11) ^ (i * 29 + 90));
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    irq_cnt += int'(irq_set);
    a_next = med_req && (!ack_alt || tog);
    tog = !tog;
    if (a_next && med_we) begin
      chk("R7", med_wdata, wpat(longint'(med_addr) / SB, int'(med_idx)));
      if (med_idx == 0) chk("R6", med_addr, exp_waddr);
      if (med_idx == 2'(SB - 1)) exp_waddr += SB;
    end
    if (a_next && !med_we) begin
      if (med_idx == 0) chk("R5,R6", med_addr, exp_raddr);
      if (med_idx == 2'(SB - 1)) exp_raddr += SB;
    end
    med_ack = a_next;
    med_rdata = rpat(longint'(med_addr) / SB, int'(med_idx));
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0; host_wr = 0; host_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_st(input logic [7:0] v, input string req);
    int t = 0;
    while (status !== v && t < 3000) begin @(negedge clk); t++; end
    chk(req, status, v);
  endtask

  task automatic issue(input logic [7:0] c);
    cmd_code = c; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic read_sector(input longint s);
    for (int i = 0; i < SB; i++) begin
      chk("R11", host_rdata, rpat(s, i));
      host_rd = 1;
      @(negedge clk);
    end
    host_rd = 0;
  endtask

  task automatic write_sector(input longint s);
    for (int i = 0; i < SB; i++) begin
      host_wdata = wpat(s, i); host_wr = 1;
      @(negedge clk);
    end
    host_wr = 0;
  endtask

  task automatic run_xfer(input vec_t v);
    int busy;
    sect_count = v.cnt; start_lba = v.lba; ready_delay = v.dly; irq_mask = v.mask;
    exp_raddr = longint'(v.lba) * SB; exp_waddr = exp_raddr;
    irq_cnt = 0;
    issue(v.cmd);
    chk("R4", status, v.wr ? 8'h08 : 8'h80);
    for (int s = 0; s < int'(v.nsec); s++) begin
      wait_st(8'h08, "R4");
      if (v.wr) write_sector(longint'(v.lba) + s);
      else      read_sector(longint'(v.lba) + s);
    end
    if (!v.wr) begin
      busy = 0;
      while (status == 8'h80 && busy < 70000) begin busy++; @(negedge clk); end
      chk("R8", busy, int'(v.dly) + 1);
      chk("R9", irq_set, !v.mask);
    end
    wait_st(8'h40, "R3");
    @(negedge clk);
    chk("R9", irq_cnt, v.nirq);
    chk("R10", proto_err, 0);
  endtask

  initial begin
    do_reset();
    chk("R1", status, 8'h40);
    chk("R1", med_req, 0);
    chk("R1", proto_err, 0);
    chk("R1", irq_set, 0);

    for (int k = 0; k < 6; k++) begin
      ack_alt = k[0];
      run_xfer(VECS[k]);
    end

    // R2: unknown codes ignored
    issue(8'hEC);
    chk("R2", status, 8'h40);
    chk("R2", med_req, 0);
    issue(8'h22);
    chk("R2", status, 8'h40);
    chk("R2", proto_err, 0);

    // R3: count zero means 256
    ack_alt = 1;
    run_xfer('{1'b0, 8'h20, 8'd0, 28'h200, 16'd1, 1'b0, 9'd256, 9'd257});
    ack_alt = 0;

    // R10: command while busy is rejected and ignored
    do_reset();
    sect_count = 1; start_lba = 28'h9; ready_delay = 30; irq_mask = 0;
    exp_raddr = 28'h9 * SB;
    issue(8'h20);
    issue(8'h30);
    chk("R10", proto_err, 1);
    chk("R10", status, 8'h80);
    wait_st(8'h08, "R10");
    read_sector(28'h9);
    wait_st(8'h40, "R10");

    // R10: host write in idle
    do_reset();
    host_wdata = 8'hA5; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    chk("R10", proto_err, 1);
    chk("R10", status, 8'h40);

    // R10: host read during fill does not move the buffer position
    do_reset();
    sect_count = 1; start_lba = 28'h77; ready_delay = 2;
    exp_waddr = 28'h77 * SB;
    issue(8'h31);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    chk("R10", proto_err, 1);
    chk("R10", status, 8'h08);
    write_sector(28'h77);
    wait_st(8'h40, "R7");
    repeat (10) @(negedge clk);
    chk("R10", proto_err, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule